// File: doc/BRIEF.md
# Byte-Lane Width Bridge

This block lets a 32-bit memory-mapped master reach a slave whose data path is only 8 bits wide. The master issues one ordinary word access: a word address, a read or write strobe, write data and four byte enables. It keeps the strobe asserted while the bridge holds `m_wait` high. The bridge turns that access into byte transactions on the slave side. Each byte transaction follows the slave's own `s_wait` handshake. When the last one finishes, the bridge drops `m_wait` for one cycle so that the master can complete.

A static parameter chooses how the narrow slave is laid out. With `MEM_MODE = 1` the slave is treated as byte-addressed memory. A word access at word address W covers slave bytes 4W to 4W+3. Those bytes are read or written in ascending order and assembled little-endian. With `MEM_MODE = 0` the slave is treated as a bank of byte registers. Word address W maps to slave register W. Only the low byte lane moves, and read data comes back zero-extended. The master issues the same access in either case.

The control is a three-state machine. `ST_IDLE` waits for a strobe. The transition *accept* latches the access and moves to `ST_XFER`. `ST_XFER` steps through the byte lanes. The transition *finish* is taken when the final lane is done, and it enters `ST_DONE`. `ST_DONE` releases the master for one cycle, and the transition *release* always returns to `ST_IDLE`.

Top module: `byte_bridge`

## Requirements
- R1: In memory mode a word access at word address W produces byte transactions at slave addresses 4W, 4W+1, 4W+2, 4W+3, in that order, and every slave address lies inside that word.
- R2: In memory mode, read data is little-endian: the byte from slave address 4W+k appears in bits 8k+7:8k (bytes AA, BB, CC, DD give 0xDDCCBBAA).
- R3: In register mode a read of word address W performs exactly one byte read at slave address W, and bits 31:8 of the returned word are zero.
- R4: In memory mode a write drives byte lane k (bits 8k+7:8k) to slave address 4W+k, lowest lane first. A lane whose byte enable bit k is 0 issues no slave write and takes one cycle.
- R5: In register mode a write issues at most one slave write, at address W, carrying bits 7:0. It is issued only when byte enable bit 0 is 1; otherwise no slave write occurs.
- R6: `m_wait` is high from the first cycle of an access until the last byte completes. An access finishes after 2 + sum over its byte transactions of (1 + slave wait cycles) negedge samples, where a skipped write lane counts 1.
- R7: While `s_wait` is high the bridge keeps its slave strobe, `s_addr` and `s_wdata` unchanged.
- R8: After the active-low reset the bridge is idle: `m_wait`, `s_read` and `s_write` are 0 and `m_rdata` is 0. The cycle after completion drives no slave strobe, and a new access may start in that cycle.
- R9: A slave strobe is only driven while the master has a request, and `s_read` and `s_write` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_addr | input | WORD_ADDR_W | Master word address |
| m_read | input | 1 | Master read strobe, held until `m_wait` is low |
| m_write | input | 1 | Master write strobe, held until `m_wait` is low |
| m_wdata | input | M_DATA_W | Master write data |
| m_byteen | input | M_DATA_W/S_DATA_W | Master byte enables |
| m_rdata | output | M_DATA_W | Master read data, valid when `m_wait` is low |
| m_wait | output | 1 | Stall the master |
| s_addr | output | WORD_ADDR_W+log2(lanes) | Slave byte address |
| s_read | output | 1 | Slave read strobe |
| s_write | output | 1 | Slave write strobe |
| s_wdata | output | S_DATA_W | Slave write data |
| s_rdata | input | S_DATA_W | Slave read data, taken when `s_wait` is low |
| s_wait | input | 1 | Slave stall |

## Verification
The bench drives both variants against one byte-array slave whose wait cycles are set per access. It measures the latency of every access against the R6 formula. A bridge that dropped a stalled byte, or advanced while the slave stalled, would show a wrong latency or a corrupted byte. The bench records the order of slave addresses, which catches big-endian packing or a lane order that starts at the wrong end. Sparse byte enables and a register-mode write with bit 0 cleared must leave neighbouring bytes untouched. Register-mode reads must return zeros above bit 7, so a design that packed stale lanes would fail.

// File: rtl/bnb_pkg.sv
package bnb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } bnb_state_e;

endpackage

// File: rtl/bnb_lane_ctr.sv
// Byte-lane sequencer: counts lanes of the current access up to LAST.
module bnb_lane_ctr #(
    parameter int LANE_W = 2,
    parameter int LAST   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [LANE_W-1:0] lane,
    output logic              at_last
);

    assign at_last = (lane == LANE_W'(LAST));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane <= '0;
        end else if (clear) begin
            lane <= '0;
        end else if (step && !at_last) begin
            lane <= lane + 1'b1;
        end
    end

endmodule

// File: rtl/bnb_lane_route.sv
// Selects the slave address, outgoing byte and lane enable for the current lane.
module bnb_lane_route #(
    parameter bit MEM_MODE    = 1'b1,
    parameter int WORD_ADDR_W = 14,
    parameter int M_DATA_W    = 32,
    parameter int S_DATA_W    = 8,
    parameter int LANE_W      = 2
) (
    input  logic [WORD_ADDR_W-1:0]        word_addr,
    input  logic [M_DATA_W-1:0]           wdata,
    input  logic [M_DATA_W/S_DATA_W-1:0]  byteen,
    input  logic [LANE_W-1:0]             lane,
    output logic [WORD_ADDR_W+LANE_W-1:0] s_addr,
    output logic [S_DATA_W-1:0]           s_wdata,
    output logic                          lane_en
);

    // In register mode the lane counter never leaves zero, so these two
    // selections reduce to the low byte and enable bit 0.
    assign s_wdata = wdata[lane*S_DATA_W +: S_DATA_W];
    assign lane_en = byteen[lane];

    generate
        if (MEM_MODE) begin : g_mem
            assign s_addr = {word_addr, lane};
        end else begin : g_reg
            assign s_addr = (WORD_ADDR_W+LANE_W)'(word_addr);
        end
    endgenerate

endmodule

// File: rtl/bnb_rd_pack.sv
// Read assembly register: one byte register per lane, cleared per access.
module bnb_rd_pack #(
    parameter int M_DATA_W = 32,
    parameter int S_DATA_W = 8,
    parameter int LANE_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                load,
    input  logic [LANE_W-1:0]   lane,
    input  logic [S_DATA_W-1:0] byte_in,
    output logic [M_DATA_W-1:0] word_out
);

    localparam int LANES = M_DATA_W / S_DATA_W;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [S_DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (clear) begin
                    q <= '0;
                end else if (load && (lane == LANE_W'(g))) begin
                    q <= byte_in;
                end
            end
            assign word_out[g*S_DATA_W +: S_DATA_W] = q;
        end
    endgenerate

endmodule

// File: rtl/byte_bridge.sv
module byte_bridge
    import bnb_pkg::*;
#(
    parameter bit MEM_MODE    = 1'b1,
    parameter int WORD_ADDR_W = 14,
    parameter int M_DATA_W    = 32,
    parameter int S_DATA_W    = 8
) (
    input  logic                                                  clk,
    input  logic                                                  rst_n,
    input  logic [WORD_ADDR_W-1:0]                                m_addr,
    input  logic                                                  m_read,
    input  logic                                                  m_write,
    input  logic [M_DATA_W-1:0]                                   m_wdata,
    input  logic [M_DATA_W/S_DATA_W-1:0]                          m_byteen,
    output logic [M_DATA_W-1:0]                                   m_rdata,
    output logic                                                  m_wait,
    output logic [WORD_ADDR_W+$clog2(M_DATA_W/S_DATA_W)-1:0]      s_addr,
    output logic                                                  s_read,
    output logic                                                  s_write,
    output logic [S_DATA_W-1:0]                                   s_wdata,
    input  logic [S_DATA_W-1:0]                                   s_rdata,
    input  logic                                                  s_wait
);

    localparam int LANES     = M_DATA_W / S_DATA_W;
    localparam int LANE_W    = $clog2(LANES);
    localparam int LAST_LANE = MEM_MODE ? LANES - 1 : 0;

    bnb_state_e state_q, state_d;

    logic                         op_wr_q;
    logic [WORD_ADDR_W-1:0]       addr_q;
    logic [M_DATA_W-1:0]          wdata_q;
    logic [LANES-1:0]             be_q;

    logic                         req;
    logic                         accept;
    logic                         step;
    logic                         slv_busy;
    logic                         lane_en;
    logic                         at_last;
    logic [LANE_W-1:0]            lane;

    assign req      = m_read | m_write;
    assign accept   = (state_q == ST_IDLE) && req;
    assign slv_busy = s_read | s_write;
    assign step     = (state_q == ST_XFER) && (!slv_busy || !s_wait);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Access capture on accept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_wr_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            op_wr_q <= m_write;
            addr_q  <= m_addr;
            wdata_q <= m_wdata;
            be_q    <= m_byteen;
        end
    end

    // Next-state logic: accept, finish, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req)             state_d = ST_XFER;
            ST_XFER: if (step && at_last) state_d = ST_DONE;
            ST_DONE:                      state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        m_wait  = 1'b0;
        s_read  = 1'b0;
        s_write = 1'b0;
        unique case (state_q)
            ST_IDLE: m_wait = req;
            ST_XFER: begin
                m_wait  = 1'b1;
                s_read  = !op_wr_q;
                s_write = op_wr_q && lane_en;
            end
            ST_DONE: m_wait = 1'b0;
            default: m_wait = 1'b0;
        endcase
    end

    bnb_lane_ctr #(
        .LANE_W (LANE_W),
        .LAST   (LAST_LANE)
    ) u_lane (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .step    (step),
        .lane    (lane),
        .at_last (at_last)
    );

    bnb_lane_route #(
        .MEM_MODE    (MEM_MODE),
        .WORD_ADDR_W (WORD_ADDR_W),
        .M_DATA_W    (M_DATA_W),
        .S_DATA_W    (S_DATA_W),
        .LANE_W      (LANE_W)
    ) u_route (
        .word_addr (addr_q),
        .wdata     (wdata_q),
        .byteen    (be_q),
        .lane      (lane),
        .s_addr    (s_addr),
        .s_wdata   (s_wdata),
        .lane_en   (lane_en)
    );

    bnb_rd_pack #(
        .M_DATA_W (M_DATA_W),
        .S_DATA_W (S_DATA_W),
        .LANE_W   (LANE_W)
    ) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .load     (step && s_read),
        .lane     (lane),
        .byte_in  (s_rdata),
        .word_out (m_rdata)
    );

endmodule

// File: rtl/bnb_checker.sv
module bnb_checker #(
    parameter bit MEM_MODE    = 1'b1,
    parameter int WORD_ADDR_W = 14,
    parameter int M_DATA_W    = 32,
    parameter int S_DATA_W    = 8
) (
    input logic                                             clk,
    input logic                                             rst_n,
    input logic [WORD_ADDR_W-1:0]                           m_addr,
    input logic                                             m_read,
    input logic                                             m_write,
    input logic [M_DATA_W-1:0]                              m_rdata,
    input logic                                             m_wait,
    input logic [WORD_ADDR_W+$clog2(M_DATA_W/S_DATA_W)-1:0] s_addr,
    input logic                                             s_read,
    input logic                                             s_write,
    input logic [S_DATA_W-1:0]                              s_wdata,
    input logic                                             s_wait
);

    localparam int LANE_W   = $clog2(M_DATA_W / S_DATA_W);
    localparam int S_ADDR_W = WORD_ADDR_W + LANE_W;

    AST_SLV_HOLD_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_read && s_wait) |=> (s_read && $stable(s_addr)));                       // R7

    AST_SLV_HOLD_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (s_write && s_wait) |=> (s_write && $stable(s_addr) && $stable(s_wdata))); // R7

    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_read && s_write));                                                      // R9

    AST_SLV_NEEDS_MST: assert property (@(posedge clk) disable iff (!rst_n)
        (s_read || s_write) |-> (m_read || m_write));                               // R9

    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((m_read || m_write) && !m_wait) |=> (!s_read && !s_write));                // R8

    generate
        if (MEM_MODE) begin : g_mem_chk
            AST_WORD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
                (s_read || s_write) |-> (s_addr[S_ADDR_W-1:LANE_W] == m_addr));     // R1
        end else begin : g_reg_chk
            AST_REG_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
                (s_read || s_write) |-> (s_addr == S_ADDR_W'(m_addr)));             // R3
            AST_ZERO_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
                (m_read && !m_wait) |-> (m_rdata[M_DATA_W-1:S_DATA_W] == '0));      // R3
        end
    endgenerate

endmodule

bind byte_bridge bnb_checker #(
    .MEM_MODE    (MEM_MODE),
    .WORD_ADDR_W (WORD_ADDR_W),
    .M_DATA_W    (M_DATA_W),
    .S_DATA_W    (S_DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .m_addr  (m_addr),
    .m_read  (m_read),
    .m_write (m_write),
    .m_rdata (m_rdata),
    .m_wait  (m_wait),
    .s_addr  (s_addr),
    .s_read  (s_read),
    .s_write (s_write),
    .s_wdata (s_wdata),
    .s_wait  (s_wait)
);

// File: tb/tb_byte_bridge.sv
module tb_byte_bridge;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [13:0] m_addr = '0;
    logic [31:0] m_wdata = '0;
    logic [3:0]  m_be = '0;
    logic        m_rd [2];
    logic        m_wr [2];
    logic        mw   [2];
    logic [31:0] rdat [2];
    logic [15:0] sa   [2];
    logic        sr   [2];
    logic        sw   [2];
    logic [7:0]  swd  [2];

    logic [7:0]  s_rdata;
    logic        s_wait;
    logic        act_rd, act_wr;
    logic [15:0] act_addr;
    logic [7:0]  act_wd;
    int          sel = 0;
    int          wait_cfg = 0;
    int          wcnt = 0;
    logic [7:0]  mem [256];

    int          nchecks = 0;
    int          nerr = 0;
    int          nseen = 0;
    logic [7:0]  seen [8];
    logic [31:0] exp_q [$];
    bit          finished = 0;

    initial begin
        m_rd[0] = 0; m_rd[1] = 0; m_wr[0] = 0; m_wr[1] = 0;
    end

    byte_bridge #(.MEM_MODE(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_read(m_rd[0]), .m_write(m_wr[0]),
        .m_wdata(m_wdata), .m_byteen(m_be), .m_rdata(rdat[0]), .m_wait(mw[0]),
        .s_addr(sa[0]), .s_read(sr[0]), .s_write(sw[0]), .s_wdata(swd[0]),
        .s_rdata(s_rdata), .s_wait(s_wait)
    );

    byte_bridge #(.MEM_MODE(1'b0)) dut_reg (
        .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_read(m_rd[1]), .m_write(m_wr[1]),
        .m_wdata(m_wdata), .m_byteen(m_be), .m_rdata(rdat[1]), .m_wait(mw[1]),
        .s_addr(sa[1]), .s_read(sr[1]), .s_write(sw[1]), .s_wdata(swd[1]),
        .s_rdata(s_rdata), .s_wait(s_wait)
    );

    // Byte-wide slave model with programmable wait cycles per transaction
    always_comb begin
        act_rd   = sr[sel];
        act_wr   = sw[sel];
        act_addr = sa[sel];
        act_wd   = swd[sel];
        s_rdata  = mem[act_addr[7:0]];
        s_wait   = (act_rd || act_wr) && (wcnt < wait_cfg);
    end

    always @(posedge clk) begin
        if (!rst_n) wcnt <= 0;
        else if ((act_rd || act_wr) && s_wait) wcnt <= wcnt + 1;
        else wcnt <= 0;
        if (rst_n && act_wr && !s_wait) mem[act_addr[7:0]] <= act_wd;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: slave acceptances and scoreboard pop on master completion
    always @(negedge clk) begin
        if (rst_n && (act_rd || act_wr) && !s_wait) begin
            if (nseen < 8) seen[nseen] = act_addr[7:0];
            nseen++;
        end
        if (m_rd[sel] && !mw[sel]) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2/R3 unexpected read completion", rdat[sel], 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(rdat[sel] == e, "R2/R3 read data", rdat[sel], e);
            end
        end
    end

    function automatic int lat_exp(input bit wr, input logic [3:0] be, input int w);
        int n = 2;
        if (sel == 0) begin
            for (int k = 0; k < 4; k++) n += (wr && !be[k]) ? 1 : 1 + w;
        end else begin
            n += (wr && !be[0]) ? 1 : 1 + w;
        end
        return n;
    endfunction

    // Driver: issues one access, pushes the expected read word, returns latency
    task automatic access(input bit wr, input logic [13:0] wa, input logic [31:0] wd,
                          input logic [3:0] be, input int w, input logic [31:0] exp,
                          output int lat);
        int n = 0;
        wait_cfg = w;
        nseen = 0;
        if (!wr) exp_q.push_back(exp);
        @(posedge clk); #1;
        m_addr = wa; m_wdata = wd; m_be = be;
        if (wr) m_wr[sel] = 1'b1; else m_rd[sel] = 1'b1;
        do begin
            @(negedge clk);
            n++;
        end while (mw[sel] && n < 200);
        @(posedge clk); #1;
        m_rd[sel] = 1'b0; m_wr[sel] = 1'b0;
        lat = n;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nchecks++; nerr++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("Result: errors=%0d of %0d checks", nerr, nchecks);
            $finish;
        end
    end

    initial begin
        int lat;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mem[8'h10] = 8'hAA; mem[8'h11] = 8'hBB; mem[8'h12] = 8'hCC; mem[8'h13] = 8'hDD;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(mw[0] == 1'b0, "R8 reset m_wait", 32'(mw[0]), 32'h0);
        check(!sr[0] && !sw[0] && !sr[1] && !sw[1], "R8 reset slave strobes", 32'(sr[0]), 32'h0);
        check(rdat[0] == 32'h0 && rdat[1] == 32'h0, "R8 reset read data", rdat[0], 32'h0);
        @(posedge clk); #1 rst_n = 1'b1;

        // ---------------- memory mode ----------------
        sel = 0;
        access(1'b0, 14'h4, 32'h0, 4'hF, 0, 32'hDDCCBBAA, lat);          // R2
        check(lat == lat_exp(0, 4'hF, 0), "R6 mem read latency", 32'(lat), 32'(lat_exp(0, 4'hF, 0)));
        check(nseen == 4, "R1 four byte reads", 32'(nseen), 32'd4);
        check(seen[0] == 8'h10 && seen[1] == 8'h11 && seen[2] == 8'h12 && seen[3] == 8'h13,
              "R1 byte order", {seen[0], seen[1], seen[2], seen[3]}, 32'h10111213);

        access(1'b0, 14'h4, 32'h0, 4'hF, 2, 32'hDDCCBBAA, lat);          // R7 value under slave wait
        check(lat == lat_exp(0, 4'hF, 2), "R7 mem read latency with slave wait", 32'(lat), 32'(lat_exp(0, 4'hF, 2)));

        access(1'b1, 14'h8, 32'h11223344, 4'hF, 1, 32'h0, lat);
        check(lat == lat_exp(1, 4'hF, 1), "R6 mem write latency", 32'(lat), 32'(lat_exp(1, 4'hF, 1)));
        check(nseen == 4 && seen[0] == 8'h20 && seen[3] == 8'h23, "R4 write lane order",
              {seen[0], seen[3], 16'(nseen)}, 32'h20230004);
        check(mem[8'h20] == 8'h44 && mem[8'h23] == 8'h11, "R4 lane zero first",
              {16'h0, mem[8'h20], mem[8'h23]}, 32'h00004411);
        access(1'b0, 14'h8, 32'h0, 4'hF, 0, 32'h11223344, lat);          // R4 read back

        access(1'b1, 14'hC, 32'hA5B6C7D8, 4'b0101, 0, 32'h0, lat);
        check(nseen == 2 && seen[0] == 8'h30 && seen[1] == 8'h32, "R4 byte enables",
              {seen[0], seen[1], 16'(nseen)}, 32'h30320002);
        check(lat == lat_exp(1, 4'b0101, 0), "R4 skipped lane timing", 32'(lat), 32'(lat_exp(1, 4'b0101, 0)));
        access(1'b0, 14'hC, 32'h0, 4'hF, 0, 32'h00B600D8, lat);          // R4 sparse read back

        access(1'b0, 14'h4, 32'h0, 4'hF, 0, 32'hDDCCBBAA, lat);          // R8 back-to-back
        check(lat == lat_exp(0, 4'hF, 0), "R8 back-to-back accept", 32'(lat), 32'(lat_exp(0, 4'hF, 0)));

        // ---------------- register mode ----------------
        sel = 1;
        access(1'b0, 14'h10, 32'h0, 4'hF, 0, 32'h000000AA, lat);         // R3
        check(nseen == 1 && seen[0] == 8'h10, "R3 single byte read", {24'(nseen), seen[0]}, 32'h00000110);
        check(lat == lat_exp(0, 4'hF, 0), "R6 reg read latency", 32'(lat), 32'(lat_exp(0, 4'hF, 0)));

        access(1'b0, 14'h10, 32'h0, 4'hF, 3, 32'h000000AA, lat);
        check(lat == lat_exp(0, 4'hF, 3), "R7 reg read latency with slave wait", 32'(lat), 32'(lat_exp(0, 4'hF, 3)));

        access(1'b1, 14'h11, 32'h12345678, 4'hF, 1, 32'h0, lat);
        check(nseen == 1 && seen[0] == 8'h11, "R5 single byte write", {24'(nseen), seen[0]}, 32'h00000111);
        check(lat == lat_exp(1, 4'hF, 1), "R5 reg write latency", 32'(lat), 32'(lat_exp(1, 4'hF, 1)));
        access(1'b0, 14'h11, 32'h0, 4'hF, 0, 32'h00000078, lat);         // R5 low byte only
        access(1'b0, 14'h12, 32'h0, 4'hF, 0, 32'h000000CC, lat);         // R5 neighbour untouched

        access(1'b1, 14'h13, 32'h99999999, 4'b1110, 0, 32'h0, lat);
        check(nseen == 0, "R5 bit0 enable clear issues no write", 32'(nseen), 32'h0);
        access(1'b0, 14'h13, 32'h0, 4'hF, 0, 32'h000000DD, lat);         // R5 register unchanged

        repeat (2) @(posedge clk);
        check(exp_q.size() == 0, "R9 scoreboard drained", 32'(exp_q.size()), 32'h0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end

endmodule